// File: doc/BRIEF.md
# Masked-Write Open-Drain Two-Wire Pin Register

This block is a single 32-bit host register through which software toggles a two-wire serial clock line and data line one access at a time. Each line has a direction bit and an output-value bit. A write changes either of them only when the write also sets the matching write-enable bit for that field. One write can therefore touch the direction of one line and leave every other field as it was, without software reading the register first.

The pads run open drain. The pad output level is tied to 0, and the pad output enable follows the direction bit. Software pulls a line low by making it an output. It lets the line go high by making it an input, after which the external pull-up raises it. Each pad input passes through a synchronizer before it appears as a readable level bit. Each line also has a pull-up-disable bit. This bit is a plain read/write bit: software writes it back unchanged on every access, so it has no write-enable bit.

All serial-protocol sequencing is left to software.

Top module: `odpin_reg`

## Requirements
- R1: After a synchronous reset, both lines are inputs (`line_oe` = 0), their value and pull-up-disable bits read 0, and `line_pu_dis` is 0.
- R2: Field layout per line, with base 0 for the clock line (line 0) and base 8 for the data line (line 1): base+0 is the direction write-enable, base+1 the direction (1 = output), base+2 the value write-enable, base+3 the value, base+4 the read-only level, and base+5 the pull-up disable. A write updates a line's direction only when its direction write-enable bit is 1. Otherwise the direction holds.
- R3: A write updates a line's value bit only when its value write-enable bit is 1. Otherwise the value holds.
- R4: `line_o` is always 0 and `line_oe` equals the line's direction bit. A line set to output reads low even while the outside world releases it.
- R5: The level bit of a line shows the pad input through a two-flop synchronizer and the registered read port. A pad change first shows on `rd_data` after the third rising clock edge.
- R6: The pull-up-disable bit of each line is loaded on every write, with no write-enable, and drives `line_pu_dis`.
- R7: The write-enable bits read back as 0, and unassigned bits read 0.
- R8: The lines are independent. Write-enable bits in one line's field group leave the other line's direction and value unchanged.
- R9: Writing the direction write-enable with direction = input, followed by a write with no write-enable bits, leaves the line released. Its level bit then returns the externally applied level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Registered read data |
| line_i | input | 2 | Pad input levels (bit 0 clock, bit 1 data) |
| line_oe | output | 2 | Pad output enables |
| line_o | output | 2 | Pad output levels (always 0) |
| line_pu_dis | output | 2 | Pull-up disable per pad |

## Verification
The hardest case to reach from the ports is a line that is set as an output while the outside world releases it. A correct block must report that line as low, because the design's own pad pulls it down. The bench models each pad as a wired-AND of the output enable and an externally applied level. It first sets a line as an output and then raises the external level, so that the level bit must stay 0. The bench also times the sampling procedure edge by edge. This shows that the level bit is still stale after two edges and updates after the third.

// File: rtl/odpin_pkg.sv
package odpin_pkg;
  localparam int FIELD_STRIDE = 8;
  localparam int OFS_DIR_WE   = 0;
  localparam int OFS_DIR      = 1;
  localparam int OFS_VAL_WE   = 2;
  localparam int OFS_VAL      = 3;
  localparam int OFS_LEVEL    = 4;
  localparam int OFS_PU_DIS   = 5;

  typedef struct packed {
    logic dir_we;
    logic dir;
    logic val_we;
    logic val;
    logic pu_dis;
  } line_cmd_t;

  typedef struct packed {
    logic dir;
    logic val;
    logic pu_dis;
  } line_state_t;
endpackage

// File: rtl/odpin_sync.sv
module odpin_sync #(
  parameter int STAGES    = 2,
  parameter bit RESET_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk) begin
    if (rst) chain_q <= {STAGES{RESET_VAL}};
    else     chain_q <= {chain_q[STAGES-2:0], d_i};
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/odpin_line.sv
module odpin_line
  import odpin_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        wr_en,
  input  line_cmd_t   cmd_i,
  output line_state_t state_o
);
  line_state_t state_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= '0;
    end else if (wr_en) begin
      if (cmd_i.dir_we) state_q.dir <= cmd_i.dir;
      if (cmd_i.val_we) state_q.val <= cmd_i.val;
      state_q.pu_dis <= cmd_i.pu_dis;
    end
  end

  assign state_o = state_q;
endmodule

// File: rtl/odpin_reg.sv
module odpin_reg
  import odpin_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int NUM_LINES   = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_en,
  input  logic [DATA_W-1:0]    wr_data,
  output logic [DATA_W-1:0]    rd_data,
  input  logic [NUM_LINES-1:0] line_i,
  output logic [NUM_LINES-1:0] line_oe,
  output logic [NUM_LINES-1:0] line_o,
  output logic [NUM_LINES-1:0] line_pu_dis
);
  localparam int USED_W = NUM_LINES * FIELD_STRIDE;

  logic [NUM_LINES-1:0] dir_q, val_q, pu_q, level_s;
  logic [DATA_W-1:0]    rd_next;

  for (genvar k = 0; k < NUM_LINES; k++) begin : g_line
    localparam int BASE = k * FIELD_STRIDE;
    line_cmd_t   cmd;
    line_state_t st;

    assign cmd.dir_we = wr_data[BASE+OFS_DIR_WE];
    assign cmd.dir    = wr_data[BASE+OFS_DIR];
    assign cmd.val_we = wr_data[BASE+OFS_VAL_WE];
    assign cmd.val    = wr_data[BASE+OFS_VAL];
    assign cmd.pu_dis = wr_data[BASE+OFS_PU_DIS];

    odpin_line u_line (
      .clk     (clk),
      .rst     (rst),
      .wr_en   (wr_en),
      .cmd_i   (cmd),
      .state_o (st)
    );

    odpin_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync (
      .clk (clk),
      .rst (rst),
      .d_i (line_i[k]),
      .q_o (level_s[k])
    );

    assign dir_q[k] = st.dir;
    assign val_q[k] = st.val;
    assign pu_q[k]  = st.pu_dis;
  end

  always_comb begin
    rd_next = '0;
    for (int k = 0; k < NUM_LINES; k++) begin
      rd_next[k*FIELD_STRIDE+OFS_DIR]    = dir_q[k];
      rd_next[k*FIELD_STRIDE+OFS_VAL]    = val_q[k];
      rd_next[k*FIELD_STRIDE+OFS_LEVEL]  = level_s[k];
      rd_next[k*FIELD_STRIDE+OFS_PU_DIS] = pu_q[k];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= rd_next;
  end

  assign line_oe     = dir_q;
  assign line_o      = '0;
  assign line_pu_dis = pu_q;

  if (USED_W > DATA_W) begin : g_bad_width
    initial $error("odpin_reg: DATA_W too small for NUM_LINES");
  end
endmodule

// File: rtl/odpin_reg_checker.sv
module odpin_reg_checker #(
  parameter int DATA_W    = 32,
  parameter int NUM_LINES = 2
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 wr_en,
  input logic [DATA_W-1:0]    wr_data,
  input logic [NUM_LINES-1:0] line_oe,
  input logic [NUM_LINES-1:0] line_o,
  input logic [NUM_LINES-1:0] line_pu_dis,
  input logic [NUM_LINES-1:0] val_q
);
  for (genvar k = 0; k < NUM_LINES; k++) begin : g_chk
    localparam int BASE = k * odpin_pkg::FIELD_STRIDE;

    // R2: direction holds without its write enable
    a_r2_dir_hold: assert property (@(posedge clk) disable iff (rst)
      !(wr_en && wr_data[BASE+odpin_pkg::OFS_DIR_WE]) |=> $stable(line_oe[k]));

    // R3: value holds without its write enable
    a_r3_val_hold: assert property (@(posedge clk) disable iff (rst)
      !(wr_en && wr_data[BASE+odpin_pkg::OFS_VAL_WE]) |=> $stable(val_q[k]));

    // R2: enabled direction write lands
    a_r2_dir_load: assert property (@(posedge clk) disable iff (rst)
      (wr_en && wr_data[BASE+odpin_pkg::OFS_DIR_WE]) |=>
        line_oe[k] == $past(wr_data[BASE+odpin_pkg::OFS_DIR]));

    // R6: pull-up disable loaded on every write
    a_r6_pu_load: assert property (@(posedge clk) disable iff (rst)
      wr_en |=> line_pu_dis[k] == $past(wr_data[BASE+odpin_pkg::OFS_PU_DIS]));

    // R4: pad output level never high
    a_r4_out_low: assert property (@(posedge clk) disable iff (rst)
      line_o[k] == 1'b0);
  end
endmodule

bind odpin_reg odpin_reg_checker #(.DATA_W(DATA_W), .NUM_LINES(NUM_LINES)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .wr_en       (wr_en),
  .wr_data     (wr_data),
  .line_oe     (line_oe),
  .line_o      (line_o),
  .line_pu_dis (line_pu_dis),
  .val_q       (val_q)
);

// File: tb/odpin_reg_tb.sv
module odpin_reg_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int W = 32;

  logic clk = 0, rst = 1, wr_en = 0;
  logic [W-1:0] wr_data = '0;
  logic [W-1:0] rd_data;
  logic [1:0] line_i, line_oe, line_o, line_pu_dis;
  logic [1:0] ext_lvl = 2'b11;
  int checks = 0, errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  // open-drain pad: driven low when enabled, else external level
  assign line_i[0] = line_oe[0] ? line_o[0] : ext_lvl[0];
  assign line_i[1] = line_oe[1] ? line_o[1] : ext_lvl[1];

  odpin_reg dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .line_i(line_i), .line_oe(line_oe), .line_o(line_o), .line_pu_dis(line_pu_dis)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // field helper: line k, bit offset
  function automatic logic [31:0] fb(int k, int ofs);
    return 32'h1 << (k*8 + ofs);
  endfunction

  // write on one edge; returns at the negedge after capture (state visible)
  task automatic wr(logic [31:0] d);
    @(negedge clk); wr_en = 1; wr_data = d;
    @(negedge clk); wr_en = 0; wr_data = '0;
  endtask

  task automatic rd_settle();
    @(negedge clk);
  endtask

  task automatic t_reset();
    check("R1 oe", line_oe, 0);
    check("R1 pu", line_pu_dis, 0);
    rd_settle();
    check("R1 rd dir/val/pu", rd_data & 32'h2A2A, 0);
  endtask

  task automatic t_dir_mask();
    wr(fb(0,1));                          // direction=1 without enable
    check("R2 no-enable", line_oe, 2'b00);
    wr(fb(0,0) | fb(0,1));                // enabled
    check("R2 enabled", line_oe, 2'b01);
    wr(fb(0,0));                          // enable with dir=0
    check("R2 release", line_oe, 2'b00);
  endtask

  task automatic t_val_mask();
    wr(fb(1,3));
    rd_settle();
    check("R3 no-enable", rd_data & fb(1,3), 0);
    wr(fb(1,2) | fb(1,3));
    rd_settle();
    check("R3 enabled", rd_data & fb(1,3), fb(1,3));
    wr(32'h0);
    rd_settle();
    check("R3 hold", rd_data & fb(1,3), fb(1,3));
    wr(fb(1,2));
    rd_settle();
    check("R3 clear", rd_data & fb(1,3), 0);
  endtask

  task automatic t_open_drain();
    ext_lvl = 2'b11;
    wr(fb(1,0) | fb(1,1) | fb(1,2) | fb(1,3)); // output with value 1
    check("R4 oe", line_oe, 2'b10);
    check("R4 o", line_o, 2'b00);
    repeat (3) @(negedge clk);
    check("R4 level low", rd_data & fb(1,4), 0);
    wr(fb(1,0));
  endtask

  task automatic t_sync();
    repeat (4) @(negedge clk);
    check("R5 idle high", rd_data & fb(0,4), fb(0,4));
    ext_lvl[0] = 0;
    repeat (2) @(negedge clk);
    check("R5 stale after 2", rd_data & fb(0,4), fb(0,4));
    @(negedge clk);
    check("R5 new after 3", rd_data & fb(0,4), 0);
    ext_lvl[0] = 1;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_pullup();
    wr(fb(0,5) | fb(1,5));
    check("R6 set", line_pu_dis, 2'b11);
    wr(fb(1,5));
    check("R6 no mask", line_pu_dis, 2'b10);
    wr(32'h0);
    check("R6 clear", line_pu_dis, 2'b00);
  endtask

  task automatic t_readback();
    wr(32'hFFFF_FFFF & ~(fb(0,1)|fb(1,1)|fb(0,3)|fb(1,3)|fb(0,5)|fb(1,5)));
    rd_settle();
    check("R7 enables read 0", rd_data & ~(fb(0,4)|fb(1,4)), 0);
  endtask

  task automatic t_indep();
    wr(fb(0,0)|fb(0,1)|fb(1,2)|fb(1,3));
    wr(fb(0,0)|fb(0,2)|fb(0,3));        // touch only line 0
    rd_settle();
    check("R8 line1 val kept", rd_data & fb(1,3), fb(1,3));
    check("R8 line1 oe kept", line_oe[1], 0);
    wr(fb(1,2));
  endtask

  task automatic t_sample();
    wr(fb(0,0)|fb(0,1));
    check("R9 driven", line_oe[0], 1);
    ext_lvl[0] = 1;
    wr(fb(0,0));                         // dir enable, input
    wr(32'h0);                           // no enables
    check("R9 released", line_oe[0], 0);
    repeat (3) @(negedge clk);
    check("R9 level", rd_data & fb(0,4), fb(0,4));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    t_reset();
    t_dir_mask();
    t_val_mask();
    t_open_drain();
    t_sync();
    t_pullup();
    t_readback();
    t_indep();
    t_sample();
    done = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule